// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block is the slave side of a three-wire control link. A host lowers an active-low select, toggles a serial clock and presents one data bit per clock. Each access is a 16-bit frame. The frame holds a 2-bit device identifier, a direction bit, a 5-bit register index and an 8-bit value. The block holds a small bank of byte registers and presents every register in parallel to the rest of a converter. There is no readback path.

All three serial lines are resynchronised into a local system clock by a two-stage synchroniser. Edges are found in that clock domain, so the system clock must be several times faster than the serial clock. The bench uses a ratio of eight.

A frame is shifted in while select is low. It is committed only when select rises. A frame is discarded when any of these is true:
- the bit count is not exactly 16;
- the prefix is wrong;
- the index is out of range;
- the master-clock qualifier is low.

An active-low power-down input returns every register to its parameter default and blocks all writes. One register bit acts as a run/restart control for downstream timing logic and is also brought out on its own pin. Writing it never disturbs the register contents.

Top module: `ctl_serial_regport`

## Requirements
- R1: A frame is 16 bits, sent first to last as: device id (2 bits, MSB first), direction bit, register index (5 bits, MSB first), data byte (MSB first). For a valid write to index `a` with byte `d`, the frame value is {2'b01, 1'b1, a[4:0], d[7:0]}, and register `a` becomes `d`.
- R2: The serial data line is sampled on rising edges of the serial clock while select is low. The host changes data after falling edges. Both select and the serial clock idle high.
- R3: A frame commits only if the device id is binary 01 and the direction bit is 1. Any other prefix leaves every register unchanged.
- R4: A write takes effect only after select rises, and only if exactly 16 rising serial-clock edges occurred while select was low. With 15 or 17 edges the frame is dropped. While select is still low, no register has changed.
- R5: A register not named by a committed frame keeps its value.
- R6: While `pdn_n` is low, every register holds its default (by default: byte 0 = 0x03, byte 1 = 0x02, bytes 2 to 7 = 0x00). A frame sent during power-down has no effect after power-down is released.
- R7: A frame whose select-rise is seen while `mclk_ok` is low is dropped.
- R8: A frame to an index of 8 or above (with the default of 8 registers) is ignored.
- R9: `timing_run_o` follows bit 0 of register 0. Clearing that bit leaves all other register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be several times faster than `sclk` |
| pdn_n | input | 1 | Active-low power-down; asynchronously restores defaults |
| mclk_ok | input | 1 | High when the converter master clock is present |
| cs_n | input | 1 | Active-low select of the serial link |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| regs_o | output | 64 | All registers, byte k at bits [8k+7:8k] |
| timing_run_o | output | 1 | Run control bit for downstream timing logic |

## Verification
The bench targets frames that are nearly right, and checks that each is dropped while the surrounding register image stays intact:
- A prefix with either id bit flipped, or with a read direction bit, must be refused. A design that checked only part of the prefix would corrupt a register.
- Frames of 15 and 17 bits must be dropped. A design that committed on the sixteenth edge, or that did not catch an overlong frame, would change a register.
- Out-of-range indices must be ignored. A design that truncated the index would alias index 8 onto register 0.
- A frame sent with the master clock missing must be dropped.
- A frame sent during power-down must be dropped. A design with ungated synchronisers could latch it.
- The register image is read while select is still low. This exposes early commits.
- Clearing the run bit is checked against all other bytes. This catches a run bit wired as a register clear.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 5;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [1:0] DEV_ID = 2'b01;

  typedef struct packed {
    logic [1:0]       dev;
    logic             dir_wr;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] val;
  } ctl_frame_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
  import ctl_regport_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_ok,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_val
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVF  = CNT_W'(FRAME_W + 1);

  logic               cs_q, sclk_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  ctl_frame_t         fr;
  logic               sclk_rise, cs_rise, cs_fall, in_range, commit_ok;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_rise   = cs_s & ~cs_q;
  assign cs_fall   = ~cs_s & cs_q;
  assign fr        = ctl_frame_t'(shreg);
  assign in_range  = {1'b0, fr.idx} < (IDX_W + 1)'(NUM_REGS);
  assign commit_ok = (cnt == CNT_FULL) && (fr.dev == DEV_ID) && fr.dir_wr
                     && in_range && mclk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_val <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
      end else if (!cs_s && sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_OVF) cnt <= cnt + 1'b1;
      end
      if (cs_rise && commit_ok) begin
        wr_en  <= 1'b1;
        wr_idx <= fr.idx;
        wr_val <= fr.val;
      end
    end
  end

  AST_ONE_COMMIT_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4
  AST_MCLK_GATES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(mclk_ok)); // R7
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regport_pkg::*;
#(
  parameter int                         NUM_REGS = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_val,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   r <= DEFAULTS[g*DATA_W +: DATA_W];
      else if (wr_en && wr_idx == IDX_W'(g))        r <= wr_val;
    end
    assign regs_o[g*DATA_W +: DATA_W] = r;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_idx} < (IDX_W + 1)'(NUM_REGS))); // R8
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R5
endmodule

// File: rtl/ctl_serial_regport.sv
module ctl_serial_regport
  import ctl_regport_pkg::*;
#(
  parameter int                         NUM_REGS = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = 64'h0000_0000_0000_0203,
  parameter int                         RUN_REG  = 0,
  parameter int                         RUN_BIT  = 0,
  parameter int                         SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       pdn_n,
  input  logic                       mclk_ok,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       timing_run_o
);
  logic [2:0]        line_s;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_val;

  ctl_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(pdn_n), .d_i({cs_n, sclk, sdi}), .q_o(line_s)
  );

  ctl_frame_rx #(.NUM_REGS(NUM_REGS)) u_rx (
    .clk(clk), .rst_n(pdn_n), .mclk_ok(mclk_ok),
    .cs_s(line_s[2]), .sclk_s(line_s[1]), .sdi_s(line_s[0]),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  ctl_regbank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst_n(pdn_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .regs_o(regs_o)
  );

  assign timing_run_o = regs_o[RUN_REG*DATA_W + RUN_BIT];

  AST_COMMIT_AFTER_SELECT_HIGH: assert property (@(posedge clk) disable iff (!pdn_n)
    wr_en |-> $past(cs_n)); // R4
endmodule

// File: tb/ctl_serial_regport_test.sv
module ctl_serial_regport_test;
  localparam logic [63:0] DEF = 64'h0000_0000_0000_0203;
  localparam int NV = 13;
  // {frame[15:0], nbits[4:0], mclk, commit, req[3:0]}
  localparam logic [26:0] VEC [NV] = '{
    {16'h6255, 5'd16, 1'b1, 1'b1, 4'd1},  // R1 reg2=55
    {16'h6711, 5'd16, 1'b1, 1'b1, 4'd1},  // R1 reg7=11
    {16'h60A5, 5'd16, 1'b1, 1'b1, 4'd5},  // R5 reg0=A5, others kept
    {16'h2344, 5'd16, 1'b1, 1'b0, 4'd3},  // R3 id 00
    {16'hA344, 5'd16, 1'b1, 1'b0, 4'd3},  // R3 id 10
    {16'h4344, 5'd16, 1'b1, 1'b0, 4'd3},  // R3 read direction
    {16'h6899, 5'd16, 1'b1, 1'b0, 4'd8},  // R8 index 8
    {16'h7F99, 5'd16, 1'b1, 1'b0, 4'd8},  // R8 index 31
    {16'h6366, 5'd15, 1'b1, 1'b0, 4'd4},  // R4 short frame
    {16'h6366, 5'd17, 1'b1, 1'b0, 4'd4},  // R4 long frame
    {16'h6377, 5'd16, 1'b0, 1'b0, 4'd7},  // R7 no master clock
    {16'h6381, 5'd16, 1'b1, 1'b1, 4'd2},  // R2 reg3=81
    {16'h6000, 5'd16, 1'b1, 1'b1, 4'd9}   // R9 clear run bit
  };

  logic clk = 1'b0, pdn_n = 1'b0, mclk_ok = 1'b1, cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [63:0] regs_o;
  logic timing_run_o;
  logic [63:0] exp_regs;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctl_serial_regport uut (
    .clk(clk), .pdn_n(pdn_n), .mclk_ok(mclk_ok), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .regs_o(regs_o), .timing_run_o(timing_run_o)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: regs actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bit actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] fr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = 1'b0;
      sdi  = (i < 16) ? fr[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send(input logic [15:0] fr, input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(fr, n);
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_regs = DEF;
    repeat (5) @(negedge clk);
    check64("R6 reset", regs_o, DEF);
    check1("R9 reset run bit", timing_run_o, 1'b1);
    pdn_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] fr;
      fr = VEC[v][26:11];
      mclk_ok = VEC[v][5];
      send(fr, int'(VEC[v][10:6]));
      mclk_ok = 1'b1;
      if (VEC[v][4]) exp_regs[fr[12:8]*8 +: 8] = fr[7:0];
      check64($sformatf("R%0d vector %0d", VEC[v][3:0], v), regs_o, exp_regs);
    end
    check1("R9 run bit cleared", timing_run_o, 1'b0);

    // R4: nothing changes while select stays low
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(16'h6412, 16);
    repeat (10) @(negedge clk);
    check64("R4 select still low", regs_o, exp_regs);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    exp_regs[4*8 +: 8] = 8'h12;
    check64("R4 after select rise", regs_o, exp_regs);

    // R6: power-down restores defaults and blocks writes
    pdn_n = 1'b0;
    @(negedge clk);
    check64("R6 power-down defaults", regs_o, DEF);
    send(16'h6533, 16);
    pdn_n = 1'b1;
    repeat (4) @(negedge clk);
    check64("R6 write during power-down", regs_o, DEF);

    exp_regs = DEF;
    send(16'h6144, 16);
    exp_regs[1*8 +: 8] = 8'h44;
    check64("R2 write after power-up", regs_o, exp_regs);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule